// File: doc/BRIEF.md
# Ping-Pong Memory-to-Memory DMA Channel

This block is a single DMA channel that copies a run of words from one address range of a synchronous memory to another while the processor does other work. Software programs a source address, a destination address, a word count and a set of mode bits through a small register port. It then sets a start bit. That bit reads back as one for as long as the channel is moving data, so software can poll it to detect completion. An interrupt line is also available for completion.

The channel moves one word at a time. It reads the word from the source address in one cycle and writes it to the destination address in the next cycle. Both addresses then advance by one word.

The channel has four ways of running:
- **One-shot:** a single pass that stops by itself.
- **Auto-reload:** the channel restarts from the programmed values after every pass until software stops it.
- **Ping-pong:** the channel moves twice the programmed count. The first half is the ping half and the second half is the pong half. It raises an event at the end of each half. A status bit tells software which half finished last.
- **Software stop:** a stop command ends any transfer at once.

Top module: `pp_dma_channel`

## Requirements
- R1: While the channel is idle, the source (select 0), destination (select 1) and length (select 2) registers read back the value last written. The control register (select 3) reads back its mode bits as written: bit1 auto-reload, bit2 ping-pong, bit3 interrupt enable.
- R2: Writing 1 to control bit0 while idle starts a transfer when the length is not zero. The start bit (control bit0) and the busy output read 1 from the cycle after the start write until the transfer ends, and then return to 0 by themselves. Status (select 4) bit0 mirrors busy.
- R3: Each word uses one read cycle at the current source address, followed by one write cycle at the current destination address. The write carries the data read. Both addresses then increase by one, and no cycle reads and writes together.
- R4: In one-shot mode the channel moves exactly the programmed number of words and then goes idle. It sets the interrupt if interrupt enable is 1, and leaves it clear otherwise.
- R5: In auto-reload mode, at the end of each pass the channel raises the pass event and restarts from the programmed source, destination and length. It stays busy until stopped.
- R6: Writing 1 to control bit4 while busy suppresses any memory access in that cycle, and busy is 0 from the next cycle. Destination words already written keep the copied data, and later ones are unchanged. The same write while idle starts nothing.
- R7: In ping-pong mode the channel moves twice the length as one contiguous run. It raises an event after the first length words and another after the second length words.
- R8: Status bit2 reads 0 after the ping half completes and 1 after the pong half completes. It is 0 after reset.
- R9: Writes to the source, destination, length and control mode bits are ignored while busy.
- R10: The interrupt output is a level that stays high until 1 is written to status bit1. An event in the same cycle as that clear leaves it set.
- R11: A start with length zero performs no memory access and leaves busy at 0. It sets the interrupt if enable is 1, using the enable bit written with the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 source, 1 destination, 2 length, 3 control, 4 status |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Read data of the selected register (combinational) |
| memAddr | output | ADDR_W | Memory word address |
| memRe | output | 1 | Memory read enable; data returns on memRdata one cycle later |
| memWe | output | 1 | Memory write enable |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Memory read data |
| irq | output | 1 | Interrupt level |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the channel with an 8-bit address, a 6-bit length and 16-bit registers and data. With these values the whole 256-word memory is small enough to check word by word after every scenario, so any stray or missing write caused by a stop, reload or half switch is caught. Short lengths of 1 to 5 words make pass and half boundaries occur every few cycles. This lets a stop, an interrupt clear or a register write land on the same cycle as a boundary event.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  localparam int REG_SEL_W = 3;

  localparam logic [REG_SEL_W-1:0] SEL_SRC  = 3'd0;
  localparam logic [REG_SEL_W-1:0] SEL_DST  = 3'd1;
  localparam logic [REG_SEL_W-1:0] SEL_LEN  = 3'd2;
  localparam logic [REG_SEL_W-1:0] SEL_CTRL = 3'd3;
  localparam logic [REG_SEL_W-1:0] SEL_STAT = 3'd4;

  localparam int CB_START  = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_PP     = 2;
  localparam int CB_IRQEN  = 3;
  localparam int CB_STOP   = 4;

  localparam int SB_BUSY = 0;
  localparam int SB_IRQ  = 1;
  localparam int SB_LAST = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } chanState_e;

  typedef struct packed {
    logic load;
    logic step;
    logic swapHalf;
    logic passEnd;
    logic reload;
    logic zeroDone;
  } chanStrobe_t;

endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        stopReq,
  input  logic        lenZero,
  input  logic        lastWord,
  input  logic        inPong,
  input  logic        ppMode,
  input  logic        autoReload,
  output logic        busy,
  output logic        memRe,
  output logic        memWe,
  output chanStrobe_t strb
);

  chanState_e state, stateNext;

  always_comb begin
    strb      = '0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (lenZero) begin
            strb.zeroDone = 1'b1;
          end else begin
            strb.load = 1'b1;
            stateNext = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (stopReq) begin
          stateNext = ST_IDLE;
        end else begin
          memRe     = 1'b1;
          stateNext = ST_WR;
        end
      end
      ST_WR: begin
        if (stopReq) begin
          stateNext = ST_IDLE;
        end else begin
          memWe     = 1'b1;
          strb.step = 1'b1;
          stateNext = ST_RD;
          if (lastWord) begin
            if (ppMode && !inPong) begin
              strb.swapHalf = 1'b1;
            end else begin
              strb.passEnd = 1'b1;
              if (autoReload) strb.reload = 1'b1;
              else            stateNext   = ST_IDLE;
            end
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(memRe)); // R3
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRe && !memWe)); // R11
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !busy); // R6
  AST_ZERO_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroDone |=> !busy); // R11
  AST_RELOAD_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> busy); // R5

endmodule

// File: rtl/pp_dma_dpath.sv
module pp_dma_dpath
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWe,
  input  logic [REG_SEL_W-1:0] regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic                 busy,
  input  logic                 memWe,
  input  chanStrobe_t          strb,
  input  logic [DATA_W-1:0]    memRdata,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  output logic                 startReq,
  output logic                 stopReq,
  output logic                 lenZero,
  output logic                 lastWord,
  output logic                 inPong,
  output logic                 ppMode,
  output logic                 autoReload,
  output logic                 irq
);

  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] cfgSrc, cfgDst, curSrc, curDst;
  logic [LEN_W-1:0]  cfgLen, remain;
  logic              cfgIrqEn, lastType, irqPend;
  logic              ctrlHit, irqClr, irqEnEff, anyEvent;

  assign ctrlHit  = regWe && (regAddr == SEL_CTRL);
  assign startReq = ctrlHit && regWdata[CB_START] && !busy;
  assign stopReq  = ctrlHit && regWdata[CB_STOP] && busy;
  assign irqClr   = regWe && (regAddr == SEL_STAT) && regWdata[SB_IRQ];
  assign irqEnEff = startReq ? regWdata[CB_IRQEN] : cfgIrqEn;
  assign anyEvent = strb.swapHalf | strb.passEnd | strb.zeroDone;
  assign lenZero  = (cfgLen == '0);
  assign lastWord = (remain == LEN_ONE);

  // configuration registers, frozen while a transfer runs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSrc     <= '0;
      cfgDst     <= '0;
      cfgLen     <= '0;
      autoReload <= 1'b0;
      ppMode     <= 1'b0;
      cfgIrqEn   <= 1'b0;
    end else if (regWe && !busy) begin
      unique case (regAddr)
        SEL_SRC: cfgSrc <= regWdata[ADDR_W-1:0];
        SEL_DST: cfgDst <= regWdata[ADDR_W-1:0];
        SEL_LEN: cfgLen <= regWdata[LEN_W-1:0];
        SEL_CTRL: begin
          autoReload <= regWdata[CB_RELOAD];
          ppMode     <= regWdata[CB_PP];
          cfgIrqEn   <= regWdata[CB_IRQEN];
        end
        default: ;
      endcase
    end
  end

  // working address and count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSrc <= '0;
      curDst <= '0;
      remain <= '0;
      inPong <= 1'b0;
    end else if (strb.load || strb.reload) begin
      curSrc <= cfgSrc;
      curDst <= cfgDst;
      remain <= cfgLen;
      inPong <= 1'b0;
    end else if (strb.step) begin
      curSrc <= curSrc + ADDR_ONE;
      curDst <= curDst + ADDR_ONE;
      if (strb.swapHalf) begin
        remain <= cfgLen;
        inPong <= 1'b1;
      end else begin
        remain <= remain - LEN_ONE;
      end
    end
  end

  // half indicator and interrupt level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastType <= 1'b0;
      irqPend  <= 1'b0;
    end else begin
      if (strb.swapHalf)                lastType <= 1'b0;
      else if (strb.passEnd && ppMode)  lastType <= 1'b1;
      if (anyEvent && irqEnEff)         irqPend  <= 1'b1;
      else if (irqClr)                  irqPend  <= 1'b0;
    end
  end

  assign memAddr  = memWe ? curDst : curSrc;
  assign memWdata = memRdata;
  assign irq      = irqPend;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      SEL_SRC: regRdata = REG_W'(cfgSrc);
      SEL_DST: regRdata = REG_W'(cfgDst);
      SEL_LEN: regRdata = REG_W'(cfgLen);
      SEL_CTRL: begin
        regRdata[CB_START]  = busy;
        regRdata[CB_RELOAD] = autoReload;
        regRdata[CB_PP]     = ppMode;
        regRdata[CB_IRQEN]  = cfgIrqEn;
      end
      SEL_STAT: begin
        regRdata[SB_BUSY] = busy;
        regRdata[SB_IRQ]  = irqPend;
        regRdata[SB_LAST] = lastType;
      end
      default: regRdata = '0;
    endcase
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(cfgSrc) && $stable(cfgDst) && $stable(cfgLen) && $stable(ppMode))); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.reload) |=> (curSrc == $past(curSrc) + ADDR_ONE)); // R3
  AST_RELOAD_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    strb.reload |=> (curSrc == $past(cfgSrc) && curDst == $past(cfgDst))); // R5
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (irqPend && !irqClr) |=> irqPend); // R10
  AST_PONG_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.passEnd && ppMode) |=> lastType); // R8
  AST_PING_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strb.swapHalf |=> (!lastType && inPong)); // R7

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              irq,
  output logic              busy
);

  chanStrobe_t strb;
  logic startReq, stopReq, lenZero, lastWord, inPong, ppMode, autoReload;

  pp_dma_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .lenZero    (lenZero),
    .lastWord   (lastWord),
    .inPong     (inPong),
    .ppMode     (ppMode),
    .autoReload (autoReload),
    .busy       (busy),
    .memRe      (memRe),
    .memWe      (memWe),
    .strb       (strb)
  );

  pp_dma_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .REG_W  (REG_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .regWe      (regWe),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .busy       (busy),
    .memWe      (memWe),
    .strb       (strb),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .startReq   (startReq),
    .stopReq    (stopReq),
    .lenZero    (lenZero),
    .lastWord   (lastWord),
    .inPong     (inPong),
    .ppMode     (ppMode),
    .autoReload (autoReload),
    .irq        (irq)
  );

endmodule

// File: tb/sim_pp_dma_channel.sv
`timescale 1ns/100ps
module sim_pp_dma_channel;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LW = 6;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWe = 1'b0;
  logic [2:0]    regAddr = '0;
  logic [RW-1:0] regWdata = '0;
  logic [RW-1:0] regRdata;
  logic [AW-1:0] memAddr;
  logic          memRe, memWe, irq, busy;
  logic [DW-1:0] memWdata;
  logic [DW-1:0] memRdata = '0;

  int nChecks = 0;
  int nFails  = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  pp_dma_channel #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .REG_W(RW)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .irq(irq), .busy(busy));

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 37 + 11) ^ 16'hA500);
  endfunction

  logic [DW-1:0] mem    [256];
  logic [DW-1:0] expMem [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]    = pat(i);
      expMem[i] = pat(i);
    end
  end

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic          mBusy, mPh, mPong, mLast, mIrq, mIrqEn, mReload, mPp;
  logic [AW-1:0] mSrc, mDst, mCfgSrc, mCfgDst;
  int            mRem, mLen;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mPh = 0; mPong = 0; mLast = 0; mIrq = 0; mIrqEn = 0;
      mReload = 0; mPp = 0; mSrc = 0; mDst = 0; mCfgSrc = 0; mCfgDst = 0;
      mRem = 0; mLen = 0;
    end else begin
      bit wasBusy, stopNow, startNow, evt, enEff;
      wasBusy  = mBusy;
      stopNow  = regWe && regAddr == 3 && regWdata[4] && wasBusy;
      startNow = regWe && regAddr == 3 && regWdata[0] && !wasBusy;
      enEff    = startNow ? regWdata[3] : mIrqEn;
      evt      = 0;
      if (stopNow) begin
        mBusy = 0;
      end else if (wasBusy) begin
        if (!mPh) mPh = 1;
        else begin
          expMem[mDst] = pat(int'(mSrc));
          mSrc++; mDst++; mRem--; mPh = 0;
          if (mRem == 0) begin
            evt = 1;
            if (mPp && !mPong) begin
              mLast = 0; mPong = 1; mRem = mLen;
            end else begin
              if (mPp) mLast = 1;
              if (mReload) begin
                mSrc = mCfgSrc; mDst = mCfgDst; mRem = mLen; mPong = 0;
              end else mBusy = 0;
            end
          end
        end
      end
      if (regWe && !wasBusy) begin
        case (regAddr)
          3'd0: mCfgSrc = regWdata[AW-1:0];
          3'd1: mCfgDst = regWdata[AW-1:0];
          3'd2: mLen    = int'(regWdata[LW-1:0]);
          3'd3: begin
            mReload = regWdata[1]; mPp = regWdata[2]; mIrqEn = regWdata[3];
            if (startNow) begin
              if (mLen == 0) evt = 1;
              else begin
                mBusy = 1; mPh = 0; mPong = 0; mRem = mLen;
                mSrc = mCfgSrc; mDst = mCfgDst;
              end
            end
          end
          default: ;
        endcase
      end
      if (regWe && regAddr == 4 && regWdata[1]) mIrq = 0;
      if (evt && enEff) mIrq = 1;
    end
  end

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && started) begin
      bit stopNow, eRe, eWe;
      stopNow = regWe && regAddr == 3 && regWdata[4] && mBusy;
      eRe = mBusy && !mPh && !stopNow;
      eWe = mBusy && mPh && !stopNow;
      chk(busy == mBusy, "R2 busy", int'(busy), int'(mBusy));
      chk(irq == mIrq, "R10 irq level", int'(irq), int'(mIrq));
      chk(memRe == eRe, "R3 read enable", int'(memRe), int'(eRe));
      chk(memWe == eWe, "R3 write enable", int'(memWe), int'(eWe));
      if (eRe) chk(memAddr == mSrc, "R3 read address", int'(memAddr), int'(mSrc));
      if (eWe) begin
        chk(memAddr == mDst, "R3 write address", int'(memAddr), int'(mDst));
        chk(memWdata == pat(int'(mSrc)), "R3 write data", int'(memWdata), int'(pat(int'(mSrc))));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic regWrite(input int a, input int d);
    regWe = 1'b1; regAddr = 3'(a); regWdata = RW'(d);
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic regRead(input int a, output int v);
    regAddr = 3'(a);
    @(negedge clk);
    v = int'(regRdata);
    @(posedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitIdle(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic waitIrq(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFails++;
    $display("FAIL R2 watchdog expired: actual 0 expected 1");
    finishRun();
  end

  // ---------------- scenarios ----------------
  initial begin
    int v;
    cyc(3);
    rstN = 1'b1;
    started = 1;
    cyc(1);

    // reset state
    regRead(0, v); chk(v == 0, "R1 reset source", v, 0);
    regRead(3, v); chk(v == 0, "R2 reset control", v, 0);
    regRead(4, v); chk(v == 0, "R8 reset status", v, 0);

    // readback of configuration
    regWrite(0, 'h10); regWrite(1, 'h80); regWrite(2, 5); regWrite(3, 'h08);
    regRead(0, v); chk(v == 'h10, "R1 source readback", v, 'h10);
    regRead(1, v); chk(v == 'h80, "R1 destination readback", v, 'h80);
    regRead(2, v); chk(v == 5, "R1 length readback", v, 5);
    regRead(3, v); chk(v == 'h08, "R1 control readback", v, 'h08);
    regWrite(3, 'h06);
    regRead(3, v); chk(v == 'h06, "R1 mode bits readback", v, 'h06);

    // one-shot with interrupt; writes while busy
    regWrite(3, 'h09);
    regRead(3, v); chk(v[0] == 1'b1, "R2 start bit while busy", v, 1);
    regWrite(0, 'h55); regWrite(2, 9); regWrite(3, 'h06);
    waitIdle(100);
    regRead(0, v); chk(v == 'h10, "R9 source unchanged", v, 'h10);
    regRead(2, v); chk(v == 5, "R9 length unchanged", v, 5);
    regRead(3, v); chk(v == 'h08, "R2 start cleared, R9 modes kept", v, 'h08);
    chk(irq == 1'b1, "R4 completion interrupt", int'(irq), 1);
    chk(mem['h84] == pat('h14), "R4 last word copied", int'(mem['h84]), int'(pat('h14)));
    chk(mem['h85] == pat('h85), "R4 no extra word", int'(mem['h85]), int'(pat('h85)));
    regWrite(4, 'h02);
    regRead(4, v); chk(v == 0, "R10 clear by write-one", v, 0);

    // one-shot without interrupt
    regWrite(0, 'h20); regWrite(1, 'h90); regWrite(2, 3); regWrite(3, 'h01);
    waitIdle(100);
    chk(irq == 1'b0, "R4 no interrupt when disabled", int'(irq), 0);
    chk(mem['h92] == pat('h22), "R4 three words copied", int'(mem['h92]), int'(pat('h22)));

    // zero length
    regWrite(2, 0); regWrite(3, 'h09);
    regRead(4, v); chk(v == 'h2, "R11 zero length done with interrupt", v, 'h2);
    regWrite(4, 'h02);

    // abort in the middle
    regWrite(0, 'h00); regWrite(1, 'hA0); regWrite(2, 30); regWrite(3, 'h01);
    cyc(7);
    regWrite(3, 'h10);
    chk(busy == 1'b0, "R6 stop ends transfer", int'(busy), 0);
    chk(mem['hA0] == pat('h00), "R6 early word copied", int'(mem['hA0]), int'(pat('h00)));
    chk(mem['hBD] == pat('hBD), "R6 late word untouched", int'(mem['hBD]), int'(pat('hBD)));
    regWrite(3, 'h10);
    cyc(3);
    chk(busy == 1'b0 && irq == 1'b0, "R6 stop while idle ignored", int'(busy), 0);

    // ping-pong
    regWrite(0, 'h30); regWrite(1, 'hC0); regWrite(2, 4); regWrite(3, 'h0D);
    waitIrq(100);
    regRead(4, v); chk(v == 'h3, "R7 ping event while busy, R8 last=0", v, 'h3);
    regWrite(4, 'h02);
    waitIrq(100);
    waitIdle(10);
    regRead(4, v); chk(v == 'h6, "R8 pong last=1 and idle", v, 'h6);
    chk(mem['hC7] == pat('h37), "R7 pong half copied", int'(mem['hC7]), int'(pat('h37)));
    chk(mem['hC8] == pat('hC8), "R7 no word past two halves", int'(mem['hC8]), int'(pat('hC8)));
    regWrite(4, 'h02);

    // auto-reload, clears racing with pass events, then stop
    regWrite(0, 'h38); regWrite(1, 'hE0); regWrite(2, 1); regWrite(3, 'h0B);
    cyc(20);
    chk(busy == 1'b1, "R5 still running after passes", int'(busy), 1);
    chk(irq == 1'b1, "R5 pass event interrupt", int'(irq), 1);
    for (int i = 0; i < 6; i++) regWrite(4, 'h02);
    regWrite(3, 'h10);
    chk(busy == 1'b0, "R5 stopped by software", int'(busy), 0);
    regWrite(4, 'h02);

    // whole memory image
    cyc(2);
    for (int i = 0; i < 256; i++)
      chk(mem[i] == expMem[i], "R3 memory image", int'(mem[i]), int'(expMem[i]));

    finishRun();
  end

endmodule